// File: doc/BRIEF.md
# Receive Line Status Tracker

This block holds received characters for a UART receive path and keeps the receive error state that software sees. Each character comes from the deserialiser with three error flags: parity, framing and break. The flags are stored in the same entry as the data bits. They reach the status word only when that character becomes the oldest one held, which is the one the next data read would return. Once reported, a flag stays set until software reads the status word. The block therefore points software at the exact character that went wrong. It does this provided software reads the status word before it takes the bad character.

There are two modes. In queued mode the storage holds up to `DEPTH` characters in arrival order. In direct mode it holds a single character, so the status reflects the character most recently accepted. A receiver status interrupt is raised from the sticky error bits and gated by an enable input. Status reads and data reads arrive as single-cycle strobes.

Top module: `rx_lsr_tracker`

## Requirements
- R1: Status bit 0 (data ready) is high exactly while at least one character is held. `rd_data` shows the oldest held character, or zero when nothing is held.
- R2: Characters leave in arrival order. A `data_rd` strobe removes the oldest character, and a `data_rd` strobe while nothing is held has no effect.
- R3: In queued mode (`fifo_en`=1) up to `DEPTH` characters are held. A character arriving while full is discarded and sets status bit 1 (overrun), unless a `data_rd` in the same cycle frees a slot, in which case it is accepted.
- R4: In direct mode (`fifo_en`=0) one character is held. A second arrival before that character is read is discarded and sets bit 1.
- R5: Status bit 2 = parity error, bit 3 = framing error, bit 4 = break. A character's flags enter these bits in the cycle it becomes the oldest held character, and not before.
- R6: Bits 4:1 are sticky. A `lsr_rd` strobe clears them after that cycle, but flags of a character that becomes oldest in that same cycle are kept. Each character's flags are reported only once.
- R7: `irq` equals `irq_en` AND the OR of status bits 4:1, so it drops after a status read.
- R8: Status bits 7:5 always read zero.
- R9: A change of `fifo_en` empties the storage in that cycle and drops any arrival in that cycle without setting overrun. The sticky bits are unaffected.
- R10: After reset nothing is held and the status word, `irq` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = queued mode, 0 = direct mode |
| rx_valid | input | 1 | A received character is presented this cycle |
| rx_data | input | DW | Received character bits |
| rx_perr | input | 1 | Parity error flag of the presented character |
| rx_ferr | input | 1 | Framing error flag of the presented character |
| rx_brk | input | 1 | Break flag of the presented character |
| lsr_rd | input | 1 | Status word read strobe |
| data_rd | input | 1 | Data read strobe |
| irq_en | input | 1 | Receiver status interrupt enable |
| rd_data | output | DW | Oldest held character |
| lsr | output | 8 | Status word |
| irq | output | 1 | Receiver status interrupt |

## Verification
The bench places a bad character behind clean ones. A design that reported flags on arrival would show the error early, while the wrong character is still at the head. It drives a status read in the same cycle as the pop that exposes a framing error. A design that let the clear win would lose that error. It repeats status reads without popping, which catches re-reporting of a head that was already seen. It also pushes while full, with and without a same-cycle pop, and changes mode with an arrival pending. Mishandling either case shows up as a lost or duplicated character, or as a false overrun.

// File: rtl/rx_lsr_tracker.sv
module rx_lsr_tracker #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          rx_brk,
  input  logic          lsr_rd,
  input  logic          data_rd,
  input  logic          irq_en,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    lsr,
  output logic          irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = DW + 3;
  localparam logic [AW:0]   FULL_Q = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp, rp_nx, wp_nx;
  logic [AW:0]   cnt, cap;
  logic          mode_q, flush, pop, push, oe_ev;
  logic [3:0]    st;
  logic [2:0]    hd_new;

  assign cap    = fifo_en ? FULL_Q : (AW+1)'(1);
  assign flush  = fifo_en != mode_q;
  assign pop    = data_rd && (cnt != '0) && !flush;
  assign push   = rx_valid && !flush && ((cnt < cap) || pop);
  assign oe_ev  = rx_valid && !flush && !push;
  assign rp_nx  = (rp == LAST) ? '0 : rp + 1'b1;
  assign wp_nx  = (wp == LAST) ? '0 : wp + 1'b1;

  always_comb begin
    hd_new = '0;
    if (push && ((cnt == '0) || (pop && cnt == (AW+1)'(1))))
      hd_new = {rx_brk, rx_ferr, rx_perr};
    else if (pop && cnt > (AW+1)'(1))
      hd_new = mem[rp_nx][EW-1:DW];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {rx_brk, rx_ferr, rx_perr, rx_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      st     <= '0;
      mode_q <= fifo_en;
    end else begin
      mode_q <= fifo_en;
      st     <= (lsr_rd ? 4'b0 : st) | {hd_new, oe_ev};
      if (flush) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push) wp <= wp_nx;
        if (pop)  rp <= rp_nx;
        cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
      end
    end
  end

  assign rd_data = (cnt != '0) ? mem[rp][DW-1:0] : '0;
  assign lsr     = {3'b000, st, cnt != '0};
  assign irq     = irq_en & (|st);
endmodule

// File: rtl/rx_lsr_tracker_chk.sv
module rx_lsr_tracker_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          rx_valid,
  input logic          lsr_rd,
  input logic          data_rd,
  input logic [DW-1:0] rd_data,
  input logic [7:0]    lsr,
  input logic          irq
);
  AST_DR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsr[0]) |-> $past(rx_valid)); // R1
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[0] && !data_rd && $stable(fifo_en) |=> lsr[0] && $stable(rd_data)); // R2
  AST_DIRECT_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en && $stable(fifo_en) && lsr[0] && rx_valid && !data_rd |=> lsr[1]); // R4
  AST_OE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[1] && !lsr_rd |=> lsr[1]); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !rx_valid && !data_rd |=> lsr[4:1] == 4'b0); // R6
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !rx_valid && !data_rd |=> !irq); // R7
  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fifo_en) |=> !lsr[0]); // R9
endmodule

bind rx_lsr_tracker rx_lsr_tracker_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_valid(rx_valid),
  .lsr_rd(lsr_rd), .data_rd(data_rd), .rd_data(rd_data), .lsr(lsr), .irq(irq)
);

// File: tb/rx_lsr_tracker_tb_top.sv
module rx_lsr_tracker_tb_top;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 1'b1, rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic lsr_rd = 1'b0, data_rd = 1'b0, irq_en = 1'b0;
  logic [7:0] rx_data = '0, rd_data, lsr;
  logic irq;

  int n_chk = 0, n_bad = 0;
  string phase = "R10 reset";

  rx_lsr_tracker #(.DEPTH(DEPTH), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .lsr_rd(lsr_rd), .data_rd(data_rd), .irq_en(irq_en),
    .rd_data(rd_data), .lsr(lsr), .irq(irq)
  );

  always #5 clk = ~clk;

  logic [10:0] q[$];
  logic [3:0]  m_st, ns;
  logic        m_mode;
  int          cap;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_st = '0; m_mode = fifo_en;
    end else if (fifo_en != m_mode) begin
      m_mode = fifo_en; q.delete();
      if (lsr_rd) m_st = '0;
    end else begin
      ns  = lsr_rd ? 4'b0 : m_st;
      cap = fifo_en ? DEPTH : 1;
      if (data_rd && q.size() > 0) begin
        void'(q.pop_front());
        if (q.size() > 0) ns[3:1] = ns[3:1] | q[0][10:8];
      end
      if (rx_valid) begin
        if (q.size() < cap) begin
          q.push_back({rx_brk, rx_ferr, rx_perr, rx_data});
          if (q.size() == 1) ns[3:1] = ns[3:1] | {rx_brk, rx_ferr, rx_perr};
        end else ns[0] = 1'b1;
      end
      m_st = ns;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk({phase, " model"}, {15'b0, irq, lsr, rd_data},
          {15'b0, irq_en & (|m_st), 3'b000, m_st, q.size() > 0,
           (q.size() > 0) ? q[0][7:0] : 8'h00});
    end
  end

  task automatic step(bit v, logic [7:0] d, bit pe, bit fe, bit bk, bit lr, bit dr);
    rx_valid = v; rx_data = d; rx_perr = pe; rx_ferr = fe; rx_brk = bk;
    lsr_rd = lr; data_rd = dr;
    @(posedge clk); #2;
  endtask

  task automatic idle();
    step(0, 8'h00, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk); #2;
    // R10 R8 reset state
    chk("R10 lsr after reset", lsr, 8'h00);
    chk("R10 rd_data after reset", rd_data, 8'h00);
    chk("R8 reserved zero", lsr[7:5], 3'b000);
    rst_n = 1'b1;
    idle();

    phase = "R1 data ready";
    step(1, 8'hA5, 0, 0, 0, 0, 0);
    chk("R1 ready after push", lsr, 8'h01);
    chk("R1 head data", rd_data, 8'hA5);

    phase = "R5 head flags";
    step(1, 8'h3C, 0, 0, 0, 0, 0);
    step(1, 8'h77, 1, 0, 0, 0, 0);
    chk("R5 error hidden behind head", lsr, 8'h01);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R2 order second", rd_data, 8'h3C);
    chk("R5 still hidden", lsr, 8'h01);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R5 parity at head", lsr, 8'h05);
    chk("R7 irq gated off", irq, 1'b0);
    irq_en = 1'b1; #1;
    chk("R7 irq on", irq, 1'b1);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R6 read clears", lsr, 8'h01);
    chk("R7 irq drops after read", irq, 1'b0);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R6 no re-report", lsr, 8'h01);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R1 empty", lsr, 8'h00);
    chk("R1 empty data zero", rd_data, 8'h00);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R2 pop when empty ignored", lsr, 8'h00);

    phase = "R3 overrun";
    for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h40 + i), 0, 0, 0, 0, 0);
    chk("R3 full no overrun", lsr, 8'h01);
    step(1, 8'hEE, 0, 0, 0, 0, 0);
    chk("R3 overrun set", lsr, 8'h03);
    chk("R3 dropped keeps head", rd_data, 8'h40);
    step(1, 8'hD1, 0, 0, 0, 0, 1);
    chk("R3 push with pop accepted", lsr, 8'h03);
    chk("R2 head after pop", rd_data, 8'h41);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R6 overrun cleared", lsr, 8'h01);
    for (int i = 0; i < DEPTH - 1; i++) step(0, 0, 0, 0, 0, 0, 1);
    chk("R3 last is accepted char", rd_data, 8'hD1);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R3 drained", lsr, 8'h00);

    phase = "R6 same cycle";
    step(1, 8'h01, 0, 0, 0, 0, 0);
    step(1, 8'h02, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1);
    chk("R6 new head flag survives read", lsr, 8'h09);
    step(0, 0, 0, 0, 0, 1, 1);
    chk("R6 cleared then empty", lsr, 8'h00);

    phase = "R4 direct";
    fifo_en = 1'b0;
    idle();
    step(1, 8'h11, 0, 0, 1, 0, 0);
    chk("R4 break on just received", lsr, 8'h11);
    step(1, 8'h22, 0, 0, 0, 0, 0);
    chk("R4 overrun in direct", lsr, 8'h13);
    chk("R4 held char kept", rd_data, 8'h11);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R4 sticky after pop", lsr, 8'h12);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R4 cleared", lsr, 8'h00);

    phase = "R9 mode change";
    fifo_en = 1'b1;
    idle();
    step(1, 8'h31, 0, 0, 0, 0, 0);
    step(1, 8'h32, 0, 0, 0, 0, 0);
    fifo_en = 1'b0;
    step(1, 8'h33, 1, 0, 0, 0, 0);
    chk("R9 flushed and arrival dropped", lsr, 8'h00);
    step(1, 8'h34, 0, 0, 0, 0, 0);
    chk("R9 accepts after change", rd_data, 8'h34);

    phase = "R2 random";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 199) == 0) fifo_en = ~fifo_en;
      if ($urandom_range(0, 49) == 0) irq_en = ~irq_en;
      step($urandom_range(0, 2) != 0, 8'($urandom), $urandom_range(0, 7) == 0,
           $urandom_range(0, 7) == 0, $urandom_range(0, 11) == 0,
           $urandom_range(0, 5) == 0, $urandom_range(0, 2) == 0);
    end
    idle();
    finish_run();
  end
endmodule